// File: doc/BRIEF.md
# PHY Control Register Bank with Bit-Masked Writes

This block is a small bank of 16-bit control words for a serial display PHY. It sits on a plain 32-bit read/write bus. Each bus write carries two halves. The lower half-word is the data. The upper half-word is a per-bit enable: a data bit reaches the register only when its enable bit is set. Software can therefore change one field without first reading the word back. Every stored bit is driven straight to the PHY. The power, divider, clock and spread-spectrum fields also come out as named ports, and the full set of words is available as one flat vector.

Two read-only status words are also part of the bank. One reports PLL readiness and the other reports a general PHY status word. Both are captured into registers every cycle, and software reads them through the same bus. The bank does no sequencing of its own. A separate controller issues the power-up and rate-change writes in whatever order the PHY needs.

Top module: `phy_ctl_bank`

## Requirements
- R1: A write of word W to a control word changes bit i to W[i] only where W[16+i] is 1. Every other bit keeps its value, and when no write is issued no control bit changes.
- R2: While `rst` is high, and in the cycle after it falls, control word 0 reads 0x0FF1 and all other control words read 0. This means the PLL and all four TX lanes are powered down, every lane is idle, and the read data output is 0.
- R3: A read issued in cycle t puts {16'h0000, value} on `bus_rdata_o` from the edge that ends cycle t. The value between reads is held.
- R4: Control word 0 (byte offset 0x00) drives `lane_idle_o` from bits 11:8, `lane_pd_o` from bits 7:4, `iddq_en_o` from bit 1 and `pll_pd_o` from bit 0.
- R5: Control word 1 (offset 0x04) drives the 15-bit `pll_fbdiv_o` from bits 14:0.
- R6: Control word 2 (offset 0x08) drives `tx_term_o` from bits 10:8, `rate_sel_o` from bits 5:4 and `ref_div_o` from bits 3:0.
- R7: Control word 6 (offset 0x18) drives `ssc_depth_o` from bits 15:12, `ssc_en_o` from bit 11 and `ssc_cnt_o` from bits 9:0.
- R8: A read of offset 0x30 returns `pll_ready_i` in bit 0 and zeros above it. A read of offset 0x34 returns `phy_sts_i` in the low half-word. Both inputs pass through one capture register, so a read returns the input value from the cycle before the read.
- R9: Writes to 0x30, 0x34, any offset at or above 0x38, and any offset whose two low bits are not 00 change no control bit.
- R10: Reads of offsets at or above 0x38, and of offsets whose two low bits are not 00, return 0.
- R11: Control word k sits at offset 4*k for k = 0..11 and appears on `ctrl_words_o` bits 16*k+15 down to 16*k.
- R12: When a read and a write to the same control word fall in the same cycle, the read returns the value from before the write. The written value appears on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | 32 | Bit enables [31:16], data [15:0] |
| bus_rdata_o | output | 32 | Registered read data |
| pll_ready_i | input | 1 | PLL ready flag from the PHY |
| phy_sts_i | input | 16 | General PHY status word |
| lane_idle_o | output | 4 | Per-lane TX idle |
| lane_pd_o | output | 4 | Per-lane TX power-down |
| iddq_en_o | output | 1 | Quiescent-current test enable |
| pll_pd_o | output | 1 | PLL power-down |
| pll_fbdiv_o | output | 15 | PLL feedback divider |
| tx_term_o | output | 3 | TX termination trim |
| rate_sel_o | output | 2 | Link rate select |
| ref_div_o | output | 4 | Reference divider |
| ssc_depth_o | output | 4 | Spread-spectrum depth |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| ssc_cnt_o | output | 10 | Spread-spectrum count |
| ctrl_words_o | output | 16*N_CTRL | All control words, word k at bits 16k+15:16k |

## Verification
The hardest case to reach from the ports is a read and a write to the same control word in the same cycle. Only that case shows whether read-back samples the register before or after the merge. The bench drives both strobes together on one negative edge. The scoreboard expects the old value for that read and the new value for the read that follows. Status capture timing is the second subtle case. The bench changes `pll_ready_i` and `phy_sts_i` and then issues reads both at once and after the capture register has settled.

// File: rtl/phy_bank_pkg.sv
package phy_bank_pkg;

    localparam int unsigned REG_W    = 16;
    localparam int unsigned BUS_W    = 2 * REG_W;
    localparam int unsigned N_LANES  = 4;
    localparam int unsigned N_CTRL_D = 12;

    // word indices whose fields leave as named ports
    localparam int unsigned IDX_PWR  = 0;
    localparam int unsigned IDX_DIV  = 1;
    localparam int unsigned IDX_CLK  = 2;
    localparam int unsigned IDX_SSC  = 6;

    // field positions
    localparam int unsigned IDLE_LSB  = 8;
    localparam int unsigned LPD_LSB   = 4;
    localparam int unsigned IDDQ_BIT  = 1;
    localparam int unsigned PLLPD_BIT = 0;
    localparam int unsigned FBDIV_W   = 15;
    localparam int unsigned TERM_LSB  = 8;
    localparam int unsigned TERM_W    = 3;
    localparam int unsigned RATE_LSB  = 4;
    localparam int unsigned RATE_W    = 2;
    localparam int unsigned RDIV_W    = 4;
    localparam int unsigned SDEP_LSB  = 12;
    localparam int unsigned SDEP_W    = 4;
    localparam int unsigned SEN_BIT   = 11;
    localparam int unsigned SCNT_W    = 10;

    localparam int unsigned STS_PLL_OFS = 'h30;
    localparam int unsigned STS_EXT_OFS = 'h34;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CTRL = 2'd1,
        RGN_PLL  = 2'd2,
        RGN_EXT  = 2'd3
    } region_e;

    typedef struct packed {
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] val;
    } mwrite_t;

    function automatic logic [REG_W-1:0] merge_bits(
        input logic [REG_W-1:0] old_w,
        input mwrite_t          req
    );
        return (old_w & ~req.en) | (req.val & req.en);
    endfunction

    // power word starts with every lane idle and powered down, PLL down
    function automatic logic [REG_W-1:0] ctrl_reset(input int unsigned idx);
        logic [REG_W-1:0] v;
        v = '0;
        if (idx == IDX_PWR) begin
            v[IDLE_LSB +: N_LANES] = '1;
            v[LPD_LSB  +: N_LANES] = '1;
            v[PLLPD_BIT]           = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/bank_addr_dec.sv
module bank_addr_dec
    import phy_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N_CTRL = N_CTRL_D
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o,
    output logic [N_CTRL-1:0] sel_o
);
    localparam logic [ADDR_W-1:0] PLL_A = ADDR_W'(STS_PLL_OFS);
    localparam logic [ADDR_W-1:0] EXT_A = ADDR_W'(STS_EXT_OFS);

    for (genvar k = 0; k < N_CTRL; k++) begin : g_hit
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(4 * k);
        assign sel_o[k] = (addr_i == OFS);
    end

    always_comb begin
        if (|sel_o)
            region_o = RGN_CTRL;
        else if (addr_i == PLL_A)
            region_o = RGN_PLL;
        else if (addr_i == EXT_A)
            region_o = RGN_EXT;
        else
            region_o = RGN_NONE;
    end
endmodule

// File: rtl/bank_ctl_word.sv
module bank_ctl_word
    import phy_bank_pkg::*;
#(
    parameter logic [REG_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  mwrite_t          req_i,
    output logic [REG_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= RST_VAL;
        else if (we_i)
            q_o <= merge_bits(q_o, req_i);
    end
endmodule

// File: rtl/bank_sts_cap.sv
module bank_sts_cap
    import phy_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pll_ready_i,
    input  logic [REG_W-1:0] ext_i,
    output logic [REG_W-1:0] pll_word_o,
    output logic [REG_W-1:0] ext_word_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pll_word_o <= '0;
            ext_word_o <= '0;
        end else begin
            pll_word_o <= {{(REG_W-1){1'b0}}, pll_ready_i};
            ext_word_o <= ext_i;
        end
    end
endmodule

// File: rtl/phy_ctl_bank.sv
module phy_ctl_bank
    import phy_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N_CTRL = N_CTRL_D
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr_i,
    input  logic                    bus_rd_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [BUS_W-1:0]        bus_wdata_i,
    output logic [BUS_W-1:0]        bus_rdata_o,
    input  logic                    pll_ready_i,
    input  logic [REG_W-1:0]        phy_sts_i,
    output logic [N_LANES-1:0]      lane_idle_o,
    output logic [N_LANES-1:0]      lane_pd_o,
    output logic                    iddq_en_o,
    output logic                    pll_pd_o,
    output logic [FBDIV_W-1:0]      pll_fbdiv_o,
    output logic [TERM_W-1:0]       tx_term_o,
    output logic [RATE_W-1:0]       rate_sel_o,
    output logic [RDIV_W-1:0]       ref_div_o,
    output logic [SDEP_W-1:0]       ssc_depth_o,
    output logic                    ssc_en_o,
    output logic [SCNT_W-1:0]       ssc_cnt_o,
    output logic [N_CTRL*REG_W-1:0] ctrl_words_o
);
    region_e           region;
    logic [N_CTRL-1:0] sel;
    mwrite_t           req;
    logic [REG_W-1:0]  ctrl_q [N_CTRL];
    logic [REG_W-1:0]  pll_word;
    logic [REG_W-1:0]  ext_word;
    logic [REG_W-1:0]  rd_word;

    assign req = mwrite_t'(bus_wdata_i);

    bank_addr_dec #(.ADDR_W(ADDR_W), .N_CTRL(N_CTRL)) u_dec (
        .addr_i   (bus_addr_i),
        .region_o (region),
        .sel_o    (sel)
    );

    for (genvar k = 0; k < N_CTRL; k++) begin : g_word
        bank_ctl_word #(.RST_VAL(ctrl_reset(k))) u_word (
            .clk   (clk),
            .rst   (rst),
            .we_i  (bus_wr_i && sel[k]),
            .req_i (req),
            .q_o   (ctrl_q[k])
        );
        assign ctrl_words_o[k*REG_W +: REG_W] = ctrl_q[k];
    end

    bank_sts_cap u_sts (
        .clk         (clk),
        .rst         (rst),
        .pll_ready_i (pll_ready_i),
        .ext_i       (phy_sts_i),
        .pll_word_o  (pll_word),
        .ext_word_o  (ext_word)
    );

    always_comb begin
        rd_word = '0;
        unique case (region)
            RGN_CTRL: begin
                for (int k = 0; k < N_CTRL; k++)
                    if (sel[k]) rd_word = ctrl_q[k];
            end
            RGN_PLL:  rd_word = pll_word;
            RGN_EXT:  rd_word = ext_word;
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata_o <= '0;
        else if (bus_rd_i)
            bus_rdata_o <= {{REG_W{1'b0}}, rd_word};
    end

    assign lane_idle_o = ctrl_q[IDX_PWR][IDLE_LSB +: N_LANES];
    assign lane_pd_o   = ctrl_q[IDX_PWR][LPD_LSB  +: N_LANES];
    assign iddq_en_o   = ctrl_q[IDX_PWR][IDDQ_BIT];
    assign pll_pd_o    = ctrl_q[IDX_PWR][PLLPD_BIT];
    assign pll_fbdiv_o = ctrl_q[IDX_DIV][0 +: FBDIV_W];
    assign tx_term_o   = ctrl_q[IDX_CLK][TERM_LSB +: TERM_W];
    assign rate_sel_o  = ctrl_q[IDX_CLK][RATE_LSB +: RATE_W];
    assign ref_div_o   = ctrl_q[IDX_CLK][0 +: RDIV_W];
    assign ssc_depth_o = ctrl_q[IDX_SSC][SDEP_LSB +: SDEP_W];
    assign ssc_en_o    = ctrl_q[IDX_SSC][SEN_BIT];
    assign ssc_cnt_o   = ctrl_q[IDX_SSC][0 +: SCNT_W];
endmodule

// File: rtl/phy_ctl_bank_chk.sv
module phy_ctl_bank_chk
    import phy_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N_CTRL = N_CTRL_D
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_wr_i,
    input logic                    bus_rd_i,
    input logic [ADDR_W-1:0]       bus_addr_i,
    input logic [BUS_W-1:0]        bus_wdata_i,
    input logic [BUS_W-1:0]        bus_rdata_o,
    input logic                    pll_ready_i,
    input logic [N_CTRL*REG_W-1:0] ctrl_words_o
);
    localparam logic [ADDR_W-1:0] HOLE_A = ADDR_W'(STS_EXT_OFS + 4);
    localparam logic [ADDR_W-1:0] PLL_A  = ADDR_W'(STS_PLL_OFS);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    assert_reset_state_R2: assert property (@(posedge clk)
        rst |=> (ctrl_words_o[REG_W-1:0] == 16'h0FF1 && bus_rdata_o == '0));

    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_i |=> $stable(ctrl_words_o));

    assert_masked_bits_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && bus_addr_i == '0) |=>
        ((ctrl_words_o[REG_W-1:0] & $past(bus_wdata_i[BUS_W-1:REG_W])) ==
         ($past(bus_wdata_i[REG_W-1:0]) & $past(bus_wdata_i[BUS_W-1:REG_W]))));

    assert_ignored_write_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && (bus_addr_i >= PLL_A || bus_addr_i[1:0] != 2'b00))
        |=> $stable(ctrl_words_o));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        bus_rd_i |=> bus_rdata_o[BUS_W-1:REG_W] == '0);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && (bus_addr_i >= HOLE_A || bus_addr_i[1:0] != 2'b00))
        |=> bus_rdata_o == '0);

    assert_pll_status_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_addr_i == PLL_A && since_rst >= 2'd2)
        |=> bus_rdata_o == {{(BUS_W-1){1'b0}}, $past(pll_ready_i, 2)});
endmodule

bind phy_ctl_bank phy_ctl_bank_chk #(.ADDR_W(ADDR_W), .N_CTRL(N_CTRL)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr_i     (bus_wr_i),
    .bus_rd_i     (bus_rd_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .pll_ready_i  (pll_ready_i),
    .ctrl_words_o (ctrl_words_o)
);

// File: tb/phy_ctl_bank_tb_top.sv
`timescale 1ns/1ps
module phy_ctl_bank_tb_top;
    localparam int AW = 8;
    localparam int NW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          pll_ready = 1'b0;
    logic [15:0]   phy_sts = '0;
    logic [3:0]    lane_idle, lane_pd;
    logic          iddq_en, pll_pd, ssc_en;
    logic [14:0]   pll_fbdiv;
    logic [2:0]    tx_term;
    logic [1:0]    rate_sel;
    logic [3:0]    ref_div, ssc_depth;
    logic [9:0]    ssc_cnt;
    logic [NW*16-1:0] ctrl_words;

    always #2.5 clk = ~clk;

    phy_ctl_bank #(.ADDR_W(AW), .N_CTRL(NW)) dut_i (
        .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .pll_ready_i(pll_ready), .phy_sts_i(phy_sts),
        .lane_idle_o(lane_idle), .lane_pd_o(lane_pd), .iddq_en_o(iddq_en),
        .pll_pd_o(pll_pd), .pll_fbdiv_o(pll_fbdiv), .tx_term_o(tx_term),
        .rate_sel_o(rate_sel), .ref_div_o(ref_div), .ssc_depth_o(ssc_depth),
        .ssc_en_o(ssc_en), .ssc_cnt_o(ssc_cnt), .ctrl_words_o(ctrl_words)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [15:0] mdl [NW];
    logic [15:0] mdl_pll, mdl_ext;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        if (a[1:0] == 2'b00 && a < 8'h30) return {16'h0, mdl[a[AW-1:2]]};
        if (a == 8'h30) return {16'h0, mdl_pll};
        if (a == 8'h34) return {16'h0, mdl_ext};
        return 32'h0;
    endfunction

    function automatic logic [191:0] model_flat();
        logic [191:0] f;
        for (int k = 0; k < NW; k++) f[k*16 +: 16] = mdl[k];
        return f;
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [15:0] en, input logic [15:0] val);
        if (a[1:0] == 2'b00 && a < 8'h30)
            mdl[a[AW-1:2]] = (mdl[a[AW-1:2]] & ~en) | (val & en);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] en, input logic [15:0] val);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = {en, val};
        model_write(a, en, val);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(model_read(a));
        tag_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // read and write to the same word in one cycle: old value expected
    task automatic do_rdwr(input logic [AW-1:0] a, input logic [15:0] en, input logic [15:0] val);
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = {en, val};
        exp_q.push_back(model_read(a));
        tag_q.push_back("R12");
        model_write(a, en, val);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    // monitor: pops one expected item for every read the design accepted
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd && !rst) begin
                #2;
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected read", 192'(bus_rdata), 192'hx);
                end else begin
                    chk(tag_q.pop_front(), 192'(bus_rdata), 192'(exp_q.pop_front()));
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < NW; k++) mdl[k] = '0;
        mdl[0] = 16'h0FF1;
        mdl_pll = '0;
        mdl_ext = '0;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 rdata", 192'(bus_rdata), 192'h0);
        chk("R2 words", 192'(ctrl_words), model_flat());
        chk("R2 lanes", {lane_idle, lane_pd, iddq_en, pll_pd}, {4'hF, 4'hF, 1'b0, 1'b1});
        rst = 1'b0;
        @(negedge clk);
        chk("R2 after release", 192'(ctrl_words[15:0]), 192'h0FF1);

        do_read(8'h00, "R3");

        // R1/R4: power up PLL alone, then release idle on lanes 0 and 1
        do_write(8'h00, 16'h0001, 16'hFFFE);
        chk("R1 pll only", 192'(ctrl_words), model_flat());
        chk("R4 pll_pd", 192'(pll_pd), 192'h0);
        do_write(8'h00, 16'h0302, 16'h0002);
        chk("R4 fields", {lane_idle, lane_pd, iddq_en, pll_pd}, {4'hC, 4'hF, 1'b1, 1'b0});

        // R5
        do_write(8'h04, 16'hFFFF, 16'hC380);
        chk("R5 fbdiv", 192'(pll_fbdiv), 192'h4380);
        do_read(8'h04, "R3 div");

        // R6
        do_write(8'h08, 16'hFFFF, 16'h0512);
        chk("R6 fields", {tx_term, rate_sel, ref_div}, {3'd5, 2'd1, 4'd2});

        // R7
        do_write(8'h18, 16'hFFFF, 16'h997D);
        chk("R7 fields", {ssc_depth, ssc_en, ssc_cnt}, {4'h9, 1'b1, 10'h17D});
        do_write(8'h18, 16'h0800, 16'h0000);
        chk("R7 ssc off", {ssc_depth, ssc_en, ssc_cnt}, {4'h9, 1'b0, 10'h17D});

        // R1: empty mask
        do_write(8'h0C, 16'hFFFF, 16'h5A5A);
        do_write(8'h0C, 16'h0000, 16'hFFFF);
        chk("R1 empty mask", 192'(ctrl_words), model_flat());

        // R11: every word at its offset and lane of the flat vector
        for (int k = 0; k < NW; k++)
            do_write(AW'(4 * k), 16'hF0F0, 16'(16'h1234 + k * 16'h1111));
        chk("R11 flat", 192'(ctrl_words), model_flat());
        for (int k = 0; k < NW; k++) do_read(AW'(4 * k), "R11 read");

        // R9: ignored writes
        do_write(8'h30, 16'hFFFF, 16'hFFFF);
        do_write(8'h34, 16'hFFFF, 16'hFFFF);
        do_write(8'h3C, 16'hFFFF, 16'hFFFF);
        do_write(8'h02, 16'hFFFF, 16'hFFFF);
        do_write(8'hFC, 16'hFFFF, 16'hFFFF);
        chk("R9 ignored", 192'(ctrl_words), model_flat());
        do_read(8'h30, "R9 status kept");

        // R8: status capture
        @(negedge clk);
        pll_ready = 1'b1; phy_sts = 16'hA5C3;
        mdl_pll = 16'h0001; mdl_ext = 16'hA5C3;
        @(negedge clk);
        do_read(8'h30, "R8 pll");
        do_read(8'h34, "R8 ext");
        @(negedge clk);
        pll_ready = 1'b0; mdl_pll = 16'h0;
        @(negedge clk);
        do_read(8'h30, "R8 pll low");

        // R10
        do_read(8'h38, "R10");
        do_read(8'hFC, "R10");
        do_read(8'h01, "R10");
        do_read(8'h07, "R10");

        // R12
        do_rdwr(8'h2C, 16'hFFFF, 16'hBEEF);
        do_read(8'h2C, "R12 new");
        chk("R12 flat", 192'(ctrl_words[11*16 +: 16]), 192'hBEEF);

        // R3: held between reads
        repeat (3) @(negedge clk);
        chk("R3 hold", 192'(bus_rdata), 192'h0000BEEF);

        repeat (3) @(negedge clk);
        chk("R3 queue drained", 192'(exp_q.size()), 192'h0);
        finish_run();
    end
endmodule